// File: doc/BRIEF.md
# Header Pin Multiplexer with Simple GPIO

This block decides, pin by pin, who drives one digital I/O header. A small general-purpose port holds an output-value register and a direction register, and each bit of them controls one odd-numbered header pin: bit X controls pin 2X+1. Two auxiliary UARTs can take over fixed odd pins. A console UART can also be routed out at TTL level on pins 0 and 2. An auxiliary UART holds its pins whenever its mode field is anything other than the "off" code.

The UARTs are outside this block. It takes their TX lines, mode fields and the TTL routing bit as inputs. It returns the header drive values and output enables, plus the receive lines each UART should listen to. Software reaches the GPIO registers over a one-bit-address register bus. Read data appears one cycle after the read request.

Top module: `hdr_pin_mux`

## Requirements
- R1: After synchronous reset, the data and direction registers are 0. With the auxiliary modes at 7 and TTL routing off, no header pin is output-enabled and both registers read back as 0 on inputs held low.
- R2: A write with address 0 loads the data register and a write with address 1 loads the direction register. A read puts its value on `bus_rdata` on the clock edge that accepts it, and the value holds until the next read. A read at address 1 returns the direction register.
- R3: When no UART owns it, odd pin 2X+1 has output enable equal to direction bit X and drives data bit X.
- R4: A read at address 0 returns, per bit X, data bit X where direction bit X is 1. Where direction bit X is 0, it returns the level of pin 2X+1 after a two-flop synchronizer.
- R5: When `aux_a_mode` is not 7, pin 5 is output-enabled and carries `aux_a_tx`, and pin 7 is an input, whatever the GPIO registers hold.
- R6: When `aux_b_mode` is not 7, pin 9 is output-enabled and carries `aux_b_tx`, and pin 11 is an input, whatever the GPIO registers hold.
- R7: When an auxiliary mode is 7, its pins follow the GPIO registers again and its RX tap (`aux_a_rx` or `aux_b_rx`) stays at idle level 1.
- R8: While an auxiliary UART is on, its RX tap follows its RX pin (pin 7 for A, pin 11 for B) with no register delay.
- R9: With `con_ttl_en` set, pin 0 is output-enabled and carries `con_tx`, pin 2 is an input, and `con_rx` follows pin 2. `con_rs232_rx` then has no effect on `con_rx`.
- R10: With `con_ttl_en` clear, `con_rx` follows `con_rs232_rx` and pins 0 and 2 are not driven. No other even-numbered pin is ever output-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data register, 1 = direction register |
| bus_wdata | input | GPIO_W | Write data |
| bus_rdata | output | GPIO_W | Read data, registered |
| con_tx | input | 1 | Console UART transmit line |
| con_rs232_rx | input | 1 | Console receive line from the RS232 transceiver |
| con_ttl_en | input | 1 | Route the console to header pins 0 and 2 |
| con_rx | output | 1 | Receive line handed to the console UART |
| aux_a_mode | input | 3 | Auxiliary UART A mode, 7 = off |
| aux_a_tx | input | 1 | Auxiliary UART A transmit line |
| aux_a_rx | output | 1 | Auxiliary UART A receive tap |
| aux_b_mode | input | 3 | Auxiliary UART B mode, 7 = off |
| aux_b_tx | input | 1 | Auxiliary UART B transmit line |
| aux_b_rx | output | 1 | Auxiliary UART B receive tap |
| pin_in | input | 2*GPIO_W | Sampled header pin levels |
| pin_out | output | 2*GPIO_W | Header pin drive values |
| pin_oe | output | 2*GPIO_W | Header pin output enables |

## Verification
The clocked checks assume `bus_sel` is a single-cycle strobe and that the mode fields and the routing bit change only between clock edges. The stimulus follows both rules. It changes every input at the falling edge, so each mode or routing change is in place for a whole cycle before the next rising edge. Pin levels are only read back after they have been held steady for longer than the synchronizer depth, so the expected readback never depends on a level caught while it is still settling.

// File: rtl/hdr_mux_pkg.sv
package hdr_mux_pkg;

    localparam logic [2:0] MODE_OFF = 3'd7;

    localparam int CON_TX_PIN  = 0;
    localparam int CON_RX_PIN  = 2;
    localparam int AUXA_TX_PIN = 5;
    localparam int AUXA_RX_PIN = 7;
    localparam int AUXB_TX_PIN = 9;
    localparam int AUXB_RX_PIN = 11;

    // lowest GPIO width that still reaches pin 11
    localparam int MIN_GPIO_W = 6;

    typedef enum logic {
        REG_DATA = 1'b0,
        REG_DIR  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic oe;
        logic val;
    } pin_drive_t;

    localparam pin_drive_t DRV_INPUT = '{oe: 1'b0, val: 1'b0};

    function automatic logic uart_active(input logic [2:0] mode);
        return mode != MODE_OFF;
    endfunction

    function automatic int gpio_to_pin(input int bit_idx);
        return 2 * bit_idx + 1;
    endfunction

endpackage

// File: rtl/hdr_pin_sync.sv
module hdr_pin_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= raw_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/hdr_gpio_regs.sv
module hdr_gpio_regs
    import hdr_mux_pkg::*;
#(
    parameter int GPIO_W = 8,
    localparam int PIN_W = 2 * GPIO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [GPIO_W-1:0] bus_wdata,
    output logic [GPIO_W-1:0] bus_rdata,
    input  logic [PIN_W-1:0]  pin_sync,
    output logic [GPIO_W-1:0] data_q,
    output logic [GPIO_W-1:0] dir_q
);
    reg_sel_e          sel;
    logic [GPIO_W-1:0] level;
    logic [GPIO_W-1:0] rd_mux;
    logic [GPIO_W-1:0] rdata_q;

    assign sel = reg_sel_e'(bus_addr);

    always_comb begin
        for (int x = 0; x < GPIO_W; x++) begin
            level[x] = dir_q[x] ? data_q[x] : pin_sync[gpio_to_pin(x)];
        end
        rd_mux = (sel == REG_DIR) ? dir_q : level;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            dir_q   <= '0;
            rdata_q <= '0;
        end else if (bus_sel) begin
            if (bus_wr) begin
                if (sel == REG_DATA) data_q <= bus_wdata;
                else                 dir_q  <= bus_wdata;
            end else begin
                rdata_q <= rd_mux;
            end
        end
    end

    assign bus_rdata = rdata_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (data_q == '0 && dir_q == '0));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr) |=> (dir_q == $past(bus_wdata)));

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
endmodule

// File: rtl/hdr_pin_route.sv
module hdr_pin_route
    import hdr_mux_pkg::*;
#(
    parameter int GPIO_W = 8,
    localparam int PIN_W = 2 * GPIO_W
) (
    input  logic [GPIO_W-1:0] data_q,
    input  logic [GPIO_W-1:0] dir_q,
    input  logic              con_tx,
    input  logic              con_rs232_rx,
    input  logic              con_ttl_en,
    input  logic [2:0]        aux_a_mode,
    input  logic              aux_a_tx,
    input  logic [2:0]        aux_b_mode,
    input  logic              aux_b_tx,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe,
    output logic              con_rx,
    output logic              aux_a_rx,
    output logic              aux_b_rx
);
    pin_drive_t drv [PIN_W];
    logic a_on, b_on;

    assign a_on = uart_active(aux_a_mode);
    assign b_on = uart_active(aux_b_mode);

    always_comb begin
        for (int p = 0; p < PIN_W; p++) drv[p] = DRV_INPUT;
        for (int x = 0; x < GPIO_W; x++) begin
            drv[gpio_to_pin(x)] = '{oe: dir_q[x], val: data_q[x]};
        end
        if (a_on) begin
            drv[AUXA_TX_PIN] = '{oe: 1'b1, val: aux_a_tx};
            drv[AUXA_RX_PIN] = DRV_INPUT;
        end
        if (b_on) begin
            drv[AUXB_TX_PIN] = '{oe: 1'b1, val: aux_b_tx};
            drv[AUXB_RX_PIN] = DRV_INPUT;
        end
        if (con_ttl_en) begin
            drv[CON_TX_PIN] = '{oe: 1'b1, val: con_tx};
            drv[CON_RX_PIN] = DRV_INPUT;
        end
    end

    genvar p;
    generate
        for (p = 0; p < PIN_W; p++) begin : g_pin
            assign pin_oe[p]  = drv[p].oe;
            assign pin_out[p] = drv[p].val;
        end
    endgenerate

    assign aux_a_rx = a_on ? pin_in[AUXA_RX_PIN] : 1'b1;
    assign aux_b_rx = b_on ? pin_in[AUXB_RX_PIN] : 1'b1;
    assign con_rx   = con_ttl_en ? pin_in[CON_RX_PIN] : con_rs232_rx;
endmodule

// File: rtl/hdr_pin_mux.sv
module hdr_pin_mux
    import hdr_mux_pkg::*;
#(
    parameter int GPIO_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int PIN_W      = 2 * GPIO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [GPIO_W-1:0] bus_wdata,
    output logic [GPIO_W-1:0] bus_rdata,
    input  logic              con_tx,
    input  logic              con_rs232_rx,
    input  logic              con_ttl_en,
    output logic              con_rx,
    input  logic [2:0]        aux_a_mode,
    input  logic              aux_a_tx,
    output logic              aux_a_rx,
    input  logic [2:0]        aux_b_mode,
    input  logic              aux_b_tx,
    output logic              aux_b_rx,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe
);
    logic [PIN_W-1:0]  pin_sync;
    logic [GPIO_W-1:0] data_q;
    logic [GPIO_W-1:0] dir_q;

    initial begin
        if (GPIO_W < MIN_GPIO_W) $error("GPIO_W too small for the UART pins");
    end

    hdr_pin_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .raw_in   (pin_in),
        .sync_out (pin_sync)
    );

    hdr_gpio_regs #(.GPIO_W(GPIO_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_sync  (pin_sync),
        .data_q    (data_q),
        .dir_q     (dir_q)
    );

    hdr_pin_route #(.GPIO_W(GPIO_W)) u_route (
        .data_q       (data_q),
        .dir_q        (dir_q),
        .con_tx       (con_tx),
        .con_rs232_rx (con_rs232_rx),
        .con_ttl_en   (con_ttl_en),
        .aux_a_mode   (aux_a_mode),
        .aux_a_tx     (aux_a_tx),
        .aux_b_mode   (aux_b_mode),
        .aux_b_tx     (aux_b_tx),
        .pin_in       (pin_in),
        .pin_out      (pin_out),
        .pin_oe       (pin_oe),
        .con_rx       (con_rx),
        .aux_a_rx     (aux_a_rx),
        .aux_b_rx     (aux_b_rx)
    );

    // R5
    aux_a_own_chk: assert property (@(posedge clk) disable iff (rst)
        (aux_a_mode != MODE_OFF) |-> (pin_oe[AUXA_TX_PIN] && !pin_oe[AUXA_RX_PIN]));

    // R6
    aux_b_own_chk: assert property (@(posedge clk) disable iff (rst)
        (aux_b_mode != MODE_OFF) |-> (pin_oe[AUXB_TX_PIN] && !pin_oe[AUXB_RX_PIN]));

    // R9
    ttl_rx_input_chk: assert property (@(posedge clk) disable iff (rst)
        con_ttl_en |-> (!pin_oe[CON_RX_PIN] && pin_oe[CON_TX_PIN]));

    genvar e;
    generate
        for (e = 2; e < PIN_W; e += 2) begin : g_even
            // R10
            even_quiet_chk: assert property (@(posedge clk) disable iff (rst)
                !pin_oe[e]);
        end
    endgenerate
endmodule

// File: tb/hdr_pin_mux_test.sv
module hdr_pin_mux_test;
    localparam int GW = 8;
    localparam int PW = 2 * GW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
    logic [GW-1:0] bus_wdata = '0;
    logic [GW-1:0] bus_rdata;
    logic con_tx = 1'b1, con_rs232_rx = 1'b1, con_ttl_en = 1'b0, con_rx;
    logic [2:0] aux_a_mode = 3'd7, aux_b_mode = 3'd7;
    logic aux_a_tx = 1'b1, aux_b_tx = 1'b1, aux_a_rx, aux_b_rx;
    logic [PW-1:0] pin_in = '0, pin_out, pin_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [GW-1:0] m_data = '0, m_dir = '0;

    logic [GW-1:0] exp_q [$];
    string         tag_q [$];
    logic          rd_pend = 1'b0;

    always #10 clk = ~clk;

    hdr_pin_mux #(.GPIO_W(GW)) uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .con_tx(con_tx),
        .con_rs232_rx(con_rs232_rx), .con_ttl_en(con_ttl_en), .con_rx(con_rx),
        .aux_a_mode(aux_a_mode), .aux_a_tx(aux_a_tx), .aux_a_rx(aux_a_rx),
        .aux_b_mode(aux_b_mode), .aux_b_tx(aux_b_tx), .aux_b_rx(aux_b_rx),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: a read accepted at a rising edge is compared at the following falling edge
    always @(posedge clk) rd_pend <= bus_sel && !bus_wr && !rst;
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R2: unexpected read data %h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), {24'h0, bus_rdata}, {24'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic bus_write(input logic a, input logic [GW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        if (a) m_dir = d; else m_data = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, input logic [GW-1:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0;
        @(negedge clk);
    endtask

    // expected pin drive from the requirements
    task automatic check_pins(input string tag);
        logic [PW-1:0] eo, ev;
        eo = '0; ev = '0;
        for (int x = 0; x < GW; x++) begin
            eo[2*x+1] = m_dir[x];
            ev[2*x+1] = m_data[x];
        end
        if (aux_a_mode != 3'd7) begin eo[5] = 1'b1; ev[5] = aux_a_tx; eo[7] = 1'b0; ev[7] = 1'b0; end
        if (aux_b_mode != 3'd7) begin eo[9] = 1'b1; ev[9] = aux_b_tx; eo[11] = 1'b0; ev[11] = 1'b0; end
        if (con_ttl_en) begin eo[0] = 1'b1; ev[0] = con_tx; eo[2] = 1'b0; ev[2] = 1'b0; end
        #2;
        check({tag, " oe"}, {16'h0, pin_oe}, {16'h0, eo});
        check({tag, " out"}, {16'h0, pin_out}, {16'h0, ev});
    endtask

    function automatic logic [GW-1:0] exp_level(input logic [PW-1:0] pins);
        logic [GW-1:0] r;
        for (int x = 0; x < GW; x++) r[x] = m_dir[x] ? m_data[x] : pins[2*x+1];
        return r;
    endfunction

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: reset state
        check_pins("R1 reset");
        bus_read(1'b0, 8'h00, "R1 data after reset");
        bus_read(1'b1, 8'h00, "R1 dir after reset");

        // R2 / R3: all outputs
        bus_write(1'b1, 8'hFF);
        bus_write(1'b0, 8'hA5);
        check_pins("R3 all out A5");
        bus_read(1'b1, 8'hFF, "R2 dir readback");
        bus_read(1'b0, 8'hA5, "R4 out path readback");
        bus_write(1'b0, 8'h5A);
        check_pins("R3 all out 5A");

        // R4: mixed directions, sampled inputs
        bus_write(1'b1, 8'h0F);
        @(negedge clk); pin_in = 16'h5A3C;
        repeat (4) @(negedge clk);
        check_pins("R3 mixed dir");
        bus_read(1'b0, exp_level(16'h5A3C), "R4 mixed readback");
        @(negedge clk); pin_in = 16'hA5C3;
        repeat (4) @(negedge clk);
        bus_read(1'b0, exp_level(16'hA5C3), "R4 new pin levels");

        // R5 / R8: aux A takes pins 5 and 7
        bus_write(1'b1, 8'hFF);
        @(negedge clk); aux_a_mode = 3'd0; aux_a_tx = 1'b0; pin_in[7] = 1'b0;
        check_pins("R5 aux A tx 0");
        check("R8 aux A rx low", {31'h0, aux_a_rx}, 32'h0);
        @(negedge clk); aux_a_tx = 1'b1; pin_in[7] = 1'b1;
        check_pins("R5 aux A tx 1");
        check("R8 aux A rx high", {31'h0, aux_a_rx}, 32'h1);

        // R6 / R8: aux B takes pins 9 and 11
        @(negedge clk); aux_b_mode = 3'd4; aux_b_tx = 1'b0; pin_in[11] = 1'b0;
        check_pins("R6 aux B tx 0");
        check("R8 aux B rx low", {31'h0, aux_b_rx}, 32'h0);
        @(negedge clk); aux_b_tx = 1'b1; pin_in[11] = 1'b1;
        check_pins("R6 aux B tx 1");
        check("R8 aux B rx high", {31'h0, aux_b_rx}, 32'h1);
        @(negedge clk); aux_b_mode = 3'd6;
        check_pins("R6 aux B mode 6");

        // R7: modes back to off
        @(negedge clk); aux_a_mode = 3'd7; aux_b_mode = 3'd7; pin_in[7] = 1'b0; pin_in[11] = 1'b0;
        check_pins("R7 modes off");
        check("R7 aux A rx idle", {31'h0, aux_a_rx}, 32'h1);
        check("R7 aux B rx idle", {31'h0, aux_b_rx}, 32'h1);

        // R9: TTL routing
        @(negedge clk); con_ttl_en = 1'b1; con_tx = 1'b0; pin_in[2] = 1'b1; con_rs232_rx = 1'b0;
        check_pins("R9 ttl tx 0");
        check("R9 rx from pin 2", {31'h0, con_rx}, 32'h1);
        @(negedge clk); con_tx = 1'b1; pin_in[2] = 1'b0; con_rs232_rx = 1'b1;
        check_pins("R9 ttl tx 1");
        check("R9 rs232 ignored", {31'h0, con_rx}, 32'h0);

        // R10: routing off
        @(negedge clk); con_ttl_en = 1'b0; con_rs232_rx = 1'b0; pin_in[2] = 1'b1;
        check_pins("R10 ttl off");
        check("R10 rx from rs232", {31'h0, con_rx}, 32'h0);
        @(negedge clk); con_rs232_rx = 1'b1;
        #2 check("R10 rx follows rs232", {31'h0, con_rx}, 32'h1);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R2: %0d reads never returned, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule